// File: doc/BRIEF.md
# SPI Slave Command Frame Engine

This block is the slave side of a serial control link. It uses mode-0 timing: the slave samples its serial input while the serial clock rises and changes its serial output while the clock falls. Every transfer is a frame of fixed length. A frame begins with a command byte and carries one to three data bytes after it. The upper two bits of the command choose the operation. The lower six bits are an address. Four operations exist: write a register, read a register, read a register and clear it, or read the constant device-information space.

The slave answers inside the frame it is receiving. While the command arrives, it sends a global status byte. While the data bytes arrive, it sends a data word. For reads, that word is the addressed location. For writes, it is the location's contents before the write. Writes and clears take effect only when chip select goes high again, and only if the frame had the configured number of clock pulses. A frame with a bad length therefore leaves the register file as it was.

The serial pins are oversampled by the block's system clock. The register file is internal and appears in full on a parallel output. The device-information space reads from an external combinational lookup port, except for one fixed address where the frame-length code is produced inside the block.

Top module: `spi_frame_engine`

## Requirements
- R1: When chip select has been high for at least four system clocks, sdo_en_o is 0. When it has been low for at least four, sdo_en_o is 1. After reset, sdo_en_o and clr_o are 0.
- R2: The first eight response bits are the status byte, MSB first. Bits 6..0 of that byte are status_i as sampled at the start of the frame. Bit 7 is the error summary: status_i[6] OR NOT status_i[5] OR any bit of status_i[4:0]. The first bit is on sdo_o before the first rising SCK. Each later bit appears after a falling SCK.
- R3: The command byte arrives MSB first. Its bits 7:6 are the operation: 00 write, 01 read, 10 read-and-clear, 11 device information. Its bits 5:0 are the address.
- R4: On a write, the response data word is the addressed register's previous value. The register takes the received data word when CSN rises.
- R5: On a read, the response data word is the addressed register's value, and no register changes.
- R6: On a read-and-clear, the response data word is the register's value. When CSN rises, the register becomes zero and clr_o pulses for one clock with clr_addr_o equal to the address.
- R7: On a device-information read, address 0x3E returns the frame-length code zero-extended: 0x01 for 16-bit frames, 0x02 for 24-bit frames, 0x03 for 32-bit frames. Any other address returns rom_data_i, looked up with rom_addr_o.
- R8: If the number of rising SCK edges in a frame differs from FRAME_BITS, no register is written or cleared and clr_o does not pulse.
- R9: Register addresses at or above REG_COUNT read as zero, and writes to them are ignored.
- R10: After reset, register i holds REG_INIT[DATA_W-1:0] XOR i.
- R11: The data word is received and sent MSB first, directly after the command byte. SDI is taken on rising SCK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, idle low |
| csn_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master |
| sdo_en_o | output | 1 | Output enable for the sdo_o pad driver |
| status_i | input | 7 | Status bits 6..0 of the response byte |
| rom_addr_o | output | 6 | Address field of the command being received |
| rom_data_i | input | FRAME_BITS-8 | Device-information word for rom_addr_o |
| regs_o | output | REG_COUNT*(FRAME_BITS-8) | All registers, register i at bits i*DATA_W |
| clr_o | output | 1 | One-clock pulse when a read-and-clear commits |
| clr_addr_o | output | 6 | Address of the cleared location |

## Verification
The bench builds the block with FRAME_BITS=24 and REG_COUNT=8. With these values the data word is 16 bits wide, so both halves of a word travel and byte order inside the word is exercised. Eight registers leave addresses 8 to 63 outside the file, which gives room for the out-of-range cases. With a 24-bit configuration, frames of 16 and 32 bits are both wrong-length frames, and the bench sends both to check the length gate.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_RDCLR = 2'b10,
        OP_INFO  = 2'b11
    } op_e;

    localparam logic [5:0] INFO_LEN_ADDR = 6'h3E;

    // Frame-length code reported in the information space
    function automatic logic [7:0] len_code(input int bits);
        case (bits)
            16:      return 8'h01;
            24:      return 8'h02;
            32:      return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    // Status byte: bit 5 is active low, the rest active high
    function automatic logic [7:0] status_byte(input logic [6:0] s);
        return {s[6] | ~s[5] | (|s[4:0]), s};
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic sdi_i,
    output logic sdi_s_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic csn_rise_o,
    output logic csn_fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] sdi;
        logic              sck_prev;
        logic              csn_prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d          = sy_q;
        sy_d.sck      = {sy_q.sck[STAGES-2:0], sck_i};
        sy_d.csn      = {sy_q.csn[STAGES-2:0], csn_i};
        sy_d.sdi      = {sy_q.sdi[STAGES-2:0], sdi_i};
        sy_d.sck_prev = sy_q.sck[STAGES-1];
        sy_d.csn_prev = sy_q.csn[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.sck      <= '0;
            sy_q.csn      <= '1;
            sy_q.sdi      <= '0;
            sy_q.sck_prev <= 1'b0;
            sy_q.csn_prev <= 1'b1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sdi_s_o    = sy_q.sdi[STAGES-1];
    assign sck_rise_o =  sy_q.sck[STAGES-1] & ~sy_q.sck_prev;
    assign sck_fall_o = ~sy_q.sck[STAGES-1] &  sy_q.sck_prev;
    assign csn_rise_o =  sy_q.csn[STAGES-1] & ~sy_q.csn_prev;
    assign csn_fall_o = ~sy_q.csn[STAGES-1] &  sy_q.csn_prev;

    // An edge is a single-cycle event
    p_edge_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise_o |=> !sck_rise_o);

endmodule

// File: rtl/spi_fe_regs.sv
module spi_fe_regs #(
    parameter int          REG_COUNT = 8,
    parameter int          DATA_W    = 8,
    parameter logic [31:0] REG_INIT  = 32'h3C5A_96A5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [5:0]                  rd_addr_i,
    output logic [DATA_W-1:0]           rd_data_o,
    input  logic                        wr_en_i,
    input  logic                        clr_en_i,
    input  logic [5:0]                  addr_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    output logic [REG_COUNT*DATA_W-1:0] regs_o
);

    typedef struct packed {
        logic [REG_COUNT-1:0][DATA_W-1:0] regs;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (addr_i == 6'(i)) begin
                if (wr_en_i)  rf_d.regs[i] = wr_data_i;
                if (clr_en_i) rf_d.regs[i] = '0;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_addr_i == 6'(i)) rd_data_o = rf_q.regs[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                rf_q.regs[i] <= REG_INIT[DATA_W-1:0] ^ DATA_W'(i);
            end
        end else begin
            rf_q <= rf_d;
        end
    end

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_flat
        assign regs_o[g*DATA_W +: DATA_W] = rf_q.regs[g];
    end

    // Register contents move only on a commit strobe
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i || clr_en_i) |=> $stable(rf_q.regs));

    // A frame commits at most one kind of update
    p_one_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && clr_en_i));

endmodule

// File: rtl/spi_fe_frame.sv
module spi_fe_frame
    import spi_fe_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sdi_s_i,
    input  logic                   sck_rise_i,
    input  logic                   sck_fall_i,
    input  logic                   csn_rise_i,
    input  logic                   csn_fall_i,
    input  logic [6:0]             status_i,
    output logic [5:0]             rd_addr_o,
    input  logic [FRAME_BITS-9:0]  reg_rd_data_i,
    input  logic [FRAME_BITS-9:0]  rom_data_i,
    output logic                   wr_en_o,
    output logic                   clr_en_o,
    output logic [5:0]             cmd_addr_o,
    output logic [FRAME_BITS-9:0]  wr_data_o,
    output logic                   sdo_o,
    output logic                   sdo_en_o
);

    localparam int DATA_W = FRAME_BITS - 8;
    localparam int CNT_W  = $clog2(FRAME_BITS) + 1;

    typedef struct packed {
        logic                  active;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] rx;
        logic [FRAME_BITS-1:0] sh;
        logic [7:0]            cmd;
        logic                  wr;
        logic                  clr;
    } frm_t;

    frm_t fr_d, fr_q;
    logic [7:0]        cur_cmd;
    logic [DATA_W-1:0] rd_word;

    // Command as it stands including the bit arriving now
    assign cur_cmd   = {fr_q.rx[6:0], sdi_s_i};
    assign rd_addr_o = cur_cmd[5:0];

    always_comb begin
        if (op_e'(cur_cmd[7:6]) == OP_INFO) begin
            if (cur_cmd[5:0] == INFO_LEN_ADDR) rd_word = DATA_W'(len_code(FRAME_BITS));
            else                               rd_word = rom_data_i;
        end else begin
            rd_word = reg_rd_data_i;
        end
    end

    always_comb begin
        fr_d     = fr_q;
        fr_d.wr  = 1'b0;
        fr_d.clr = 1'b0;
        if (!fr_q.active) begin
            if (csn_fall_i) begin
                fr_d.active = 1'b1;
                fr_d.cnt    = '0;
                fr_d.rx     = '0;
                fr_d.sh     = {status_byte(status_i), {DATA_W{1'b0}}};
            end
        end else if (csn_rise_i) begin
            fr_d.active = 1'b0;
            if (fr_q.cnt == CNT_W'(FRAME_BITS)) begin
                case (op_e'(fr_q.cmd[7:6]))
                    OP_WRITE: fr_d.wr  = 1'b1;
                    OP_RDCLR: fr_d.clr = 1'b1;
                    default:  ;
                endcase
            end
        end else begin
            if (sck_rise_i) begin
                if (fr_q.cnt != '1) fr_d.cnt = fr_q.cnt + 1'b1;
                fr_d.rx = {fr_q.rx[FRAME_BITS-2:0], sdi_s_i};
                if (fr_q.cnt == CNT_W'(7)) begin
                    fr_d.cmd                       = cur_cmd;
                    fr_d.sh[FRAME_BITS-2 -: DATA_W] = rd_word;
                end
            end
            if (sck_fall_i) begin
                fr_d.sh = {fr_q.sh[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign sdo_o      = fr_q.sh[FRAME_BITS-1];
    assign sdo_en_o   = fr_q.active;
    assign wr_en_o    = fr_q.wr;
    assign clr_en_o   = fr_q.clr;
    assign cmd_addr_o = fr_q.cmd[5:0];
    assign wr_data_o  = fr_q.rx[DATA_W-1:0];

    p_sdo_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.active && sck_fall_i && !csn_rise_i) |=> sdo_o == $past(fr_q.sh[FRAME_BITS-2]));

    p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.active && csn_rise_i) |=> !sdo_en_o);

    p_len_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.active && csn_rise_i && fr_q.cnt != CNT_W'(FRAME_BITS)) |=> !(wr_en_o || clr_en_o));

    p_cmd_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.active && sck_rise_i && !csn_rise_i && fr_q.cnt == CNT_W'(7)) |=> cmd_addr_o == $past(rd_addr_o));

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
    parameter int          FRAME_BITS = 16,
    parameter int          REG_COUNT  = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] REG_INIT   = 32'h3C5A_96A5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  sck_i,
    input  logic                                  csn_i,
    input  logic                                  sdi_i,
    output logic                                  sdo_o,
    output logic                                  sdo_en_o,
    input  logic [6:0]                            status_i,
    output logic [5:0]                            rom_addr_o,
    input  logic [FRAME_BITS-9:0]                 rom_data_i,
    output logic [REG_COUNT*(FRAME_BITS-8)-1:0]   regs_o,
    output logic                                  clr_o,
    output logic [5:0]                            clr_addr_o
);

    localparam int DATA_W = FRAME_BITS - 8;

    logic              sdi_s, sck_rise, sck_fall, csn_rise, csn_fall;
    logic [5:0]        rd_addr, cmd_addr;
    logic [DATA_W-1:0] reg_rd_data, wr_data;
    logic              wr_en, clr_en;

    spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .csn_i      (csn_i),
        .sdi_i      (sdi_i),
        .sdi_s_o    (sdi_s),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .csn_rise_o (csn_rise),
        .csn_fall_o (csn_fall)
    );

    spi_fe_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .sdi_s_i       (sdi_s),
        .sck_rise_i    (sck_rise),
        .sck_fall_i    (sck_fall),
        .csn_rise_i    (csn_rise),
        .csn_fall_i    (csn_fall),
        .status_i      (status_i),
        .rd_addr_o     (rd_addr),
        .reg_rd_data_i (reg_rd_data),
        .rom_data_i    (rom_data_i),
        .wr_en_o       (wr_en),
        .clr_en_o      (clr_en),
        .cmd_addr_o    (cmd_addr),
        .wr_data_o     (wr_data),
        .sdo_o         (sdo_o),
        .sdo_en_o      (sdo_en_o)
    );

    spi_fe_regs #(
        .REG_COUNT (REG_COUNT),
        .DATA_W    (DATA_W),
        .REG_INIT  (REG_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (rd_addr),
        .rd_data_o (reg_rd_data),
        .wr_en_i   (wr_en),
        .clr_en_i  (clr_en),
        .addr_i    (cmd_addr),
        .wr_data_i (wr_data),
        .regs_o    (regs_o)
    );

    assign rom_addr_o = rd_addr;
    assign clr_o      = clr_en;
    assign clr_addr_o = cmd_addr;

    p_clr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !clr_o);

endmodule

// File: tb/test_spi_frame_engine.sv
module test_spi_frame_engine;

    localparam int          CLK_PERIOD = 10;
    localparam int          HALF       = 8;
    localparam int          FB         = 24;
    localparam int          RC         = 8;
    localparam int          DW         = FB - 8;
    localparam logic [31:0] INIT       = 32'h3C5A_96A5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sck, csn, sdi;
    logic             sdo_o, sdo_en_o;
    logic [6:0]       st;
    logic [5:0]       rom_addr_o;
    logic [DW-1:0]    rom_data_i;
    logic [RC*DW-1:0] regs_o;
    logic             clr_o;
    logic [5:0]       clr_addr_o;

    int checks = 0;
    int fails  = 0;
    int clr_count = 0;
    logic [5:0] clr_last = '0;
    logic [DW-1:0] mreg [RC];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rom_data_i = {rom_addr_o, 2'b10, ~rom_addr_o, 2'b01};

    spi_frame_engine #(
        .FRAME_BITS (FB),
        .REG_COUNT  (RC),
        .REG_INIT   (INIT)
    ) i_spi_frame_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck),
        .csn_i      (csn),
        .sdi_i      (sdi),
        .sdo_o      (sdo_o),
        .sdo_en_o   (sdo_en_o),
        .status_i   (st),
        .rom_addr_o (rom_addr_o),
        .rom_data_i (rom_data_i),
        .regs_o     (regs_o),
        .clr_o      (clr_o),
        .clr_addr_o (clr_addr_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (clr_o) begin
            clr_count = clr_count + 1;
            clr_last  = clr_addr_o;
        end
    end

    // Every-clock check of the output enable against settled chip select (R1)
    int   csn_age = 0;
    logic csn_prev = 1'b1;
    always @(negedge clk) begin
        if (csn !== csn_prev) csn_age = 0;
        else                  csn_age++;
        csn_prev = csn;
        if (rst_n && csn_age >= 4)
            check(sdo_en_o == !csn, "R1", "sdo_en_o vs settled csn", 64'(sdo_en_o), 64'(!csn));
    end

    function automatic logic [DW-1:0] rom_model(input logic [5:0] a);
        return {a, 2'b10, ~a, 2'b01};
    endfunction

    function automatic logic [DW-1:0] word_model(input logic [7:0] c);
        if (c[7:6] == 2'b11) return (c[5:0] == 6'h3E) ? DW'(8'h02) : rom_model(c[5:0]);
        if (int'(c[5:0]) < RC) return mreg[int'(c[5:0])];
        return '0;
    endfunction

    task automatic check_regs(input string req);
        logic [RC*DW-1:0] exp;
        for (int i = 0; i < RC; i++) exp[i*DW +: DW] = mreg[i];
        check(regs_o == exp, req, "register file", 64'(regs_o), 64'(exp));
    endtask

    task automatic frame(input logic [7:0] cmd, input logic [DW-1:0] data,
                         input int nbits, input string req);
        logic [FB-1:0] tx, exp, got, mask;
        logic [7:0]    sb;
        int            clr_before;
        tx   = {cmd, data};
        sb   = {st[6] | ~st[5] | (|st[4:0]), st};
        exp  = {sb, word_model(cmd)};
        got  = '0;
        mask = (nbits >= FB) ? '1 : ~({FB{1'b1}} >> nbits);
        clr_before = clr_count;
        csn = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < FB) ? tx[FB-1-i] : 1'b0;
            wait_clk(HALF);
            if (i < FB) got[FB-1-i] = sdo_o;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(HALF);
        check((got & mask) == (exp & mask), req, "in-frame response", 64'(got & mask), 64'(exp & mask));
        if (nbits == FB) begin
            if (cmd[7:6] == 2'b00 && int'(cmd[5:0]) < RC) mreg[int'(cmd[5:0])] = data;
            if (cmd[7:6] == 2'b10) begin
                if (int'(cmd[5:0]) < RC) mreg[int'(cmd[5:0])] = '0;
                check(clr_count == clr_before + 1 && clr_last == cmd[5:0], "R6", "clear strobe",
                      64'({clr_count - clr_before, 2'b00, clr_last}), 64'({32'd1, 2'b00, cmd[5:0]}));
            end
        end
        if (!(nbits == FB && cmd[7:6] == 2'b10))
            check(clr_count == clr_before, req, "no clear strobe", 64'(clr_count - clr_before), 64'd0);
        check_regs(req);
        check(sdo_en_o == 1'b0, "R1", "deselected after frame", 64'(sdo_en_o), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sck = 1'b0; csn = 1'b1; sdi = 1'b0; st = 7'h20;
        for (int i = 0; i < RC; i++) mreg[i] = INIT[DW-1:0] ^ DW'(i);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // Reset state (R10, R1)
        check(sdo_en_o == 1'b0 && clr_o == 1'b0, "R1", "reset outputs",
              64'({sdo_en_o, clr_o}), 64'd0);
        check_regs("R10");

        // Reads with different status patterns (R5, R2, R3)
        st = 7'h20; frame(8'h43, 16'h0000, FB, "R5");
        st = 7'h00; frame(8'h45, 16'hFFFF, FB, "R2");
        st = 7'h61; frame(8'h40, 16'h0000, FB, "R2");

        // Write returns the old value, then commit (R4, R11)
        st = 7'h20;
        frame(8'h03, 16'hBEEF, FB, "R4");
        frame(8'h43, 16'h0000, FB, "R11");
        frame(8'h00, 16'h1234, FB, "R4");
        frame(8'h00, 16'h8001, FB, "R11");

        // Read-and-clear (R6)
        frame(8'h83, 16'h0000, FB, "R6");
        frame(8'h43, 16'h0000, FB, "R6");

        // Information space (R7)
        frame(8'hFE, 16'h0000, FB, "R7");
        frame(8'hC5, 16'h0000, FB, "R7");
        frame(8'hC3, 16'hAAAA, FB, "R7");

        // Wrong-length frames (R8)
        frame(8'h01, 16'h5555, 16, "R8");
        frame(8'h01, 16'h5555, 32, "R8");
        frame(8'h80, 16'h0000, 16, "R8");
        frame(8'h80, 16'h0000, 23, "R8");

        // Out-of-range addresses (R9)
        frame(8'h20, 16'hCAFE, FB, "R9");
        frame(8'h60, 16'h0000, FB, "R9");
        frame(8'h88, 16'h0000, FB, "R9");

        // Walk all registers with two patterns (R4, R5)
        for (int i = 0; i < RC; i++) frame(8'(i), DW'(16'h0F0F ^ (i * 16'h1111)), FB, "R4");
        for (int i = 0; i < RC; i++) frame(8'h40 | 8'(i), 16'h0000, FB, "R5");
        for (int i = 0; i < RC; i++) frame(8'(i), DW'(16'hF00D + i), FB, "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule